// File: doc/BRIEF.md
# Parallel Port Peripheral Byte Receiver

This block sits on the peripheral end of a byte-wide, host-driven parallel printer port working in compatibility mode. The host places a byte on the eight data lines and pulses its active-low strobe. The block brings the strobe into the local clock domain and captures the byte at the strobe's trailing (rising) edge. At the same moment it records whether the host's active-low auto-feed line was asserted, which marks the byte as a command rather than plain data. The captured byte is offered to local logic through a valid/ready pair.

BUSY goes up as soon as a strobe is seen. It stays up while the local side leaves the byte untaken, so local back-pressure reaches the host directly. Once the byte is taken, the block drives a fixed-length active-low acknowledge pulse and drops BUSY at the end of that pulse. If the host strobes again while a byte is still held or being acknowledged, the new byte is discarded and a sticky overrun flag is set. The host's active-low initialise line returns the receive side to idle, empties it and clears the overrun flag, and no acknowledge follows. Select, paper-error and active-low fault outputs report local status. Select is only shown while the host's select-in request is asserted.

Top module: `parport_rx`

## Requirements
- R1: After reset, ackN is 1, busy is 0, rxValid is 0, overrun is 0 and rxData is 0.
- R2: The value on hostData at the trailing (low-to-high) edge of hostStrobeN appears on rxData with rxValid set to 1, within SYNC_STAGES+2 clocks of that edge.
- R3: rxCmd is 1 when hostAutoFeedN was low at capture, and 0 when it was high.
- R4: busy goes to 1 within SYNC_STAGES+2 clocks of the leading (high-to-low) edge of hostStrobeN, before any byte is presented.
- R5: While rxValid is 1, rxData and rxCmd do not change.
- R6: The first clock after a cycle with rxValid and rxReady both 1, ackN goes to 0. It stays 0 for exactly ACK_CYCLES clocks. busy returns to 0 in the same clock that ackN returns to 1.
- R7: ackN only goes low in the clock after a byte was taken.
- R8: A trailing strobe edge while a byte is held or being acknowledged sets overrun to 1 and leaves rxData and rxCmd unchanged. overrun stays 1 until an initialise.
- R9: hostInitN low for SYNC_STAGES+1 clocks clears rxValid, busy, overrun and rxData to 0. No acknowledge pulse follows.
- R10: select is 1 only when localOnline is 1 and hostSelectInN is low. paperErr follows localPaperOut. faultN is the inverse of localFault.
- R11: While rxReady stays 0, a held byte keeps rxValid and busy at 1 and ackN at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostData | input | DATA_W | Data lines from the host |
| hostStrobeN | input | 1 | Host strobe, active low |
| hostAutoFeedN | input | 1 | Host auto-feed, low marks a command byte |
| hostInitN | input | 1 | Host initialise, active low |
| hostSelectInN | input | 1 | Host select-in request, active low |
| localOnline | input | 1 | Local on-line status |
| localPaperOut | input | 1 | Local paper problem status |
| localFault | input | 1 | Local fault status |
| rxReady | input | 1 | Local side takes the presented byte |
| ackN | output | 1 | Acknowledge pulse to host, active low |
| busy | output | 1 | Port cannot accept a byte |
| selectOut | output | 1 | On-line status to host |
| paperErr | output | 1 | Paper error status to host |
| faultN | output | 1 | Fault status to host, active low |
| rxData | output | DATA_W | Captured byte |
| rxCmd | output | 1 | Captured byte is an auto-feed command |
| rxValid | output | 1 | A captured byte is waiting |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
Each internal fault shows up at the ports within one transfer. If the sequencer state is wrong, BUSY and acknowledge move out of step: an acknowledge pulse of the wrong length, BUSY dropping before acknowledge rises, or a pulse with no byte taken. Each of these is visible in the same clock as the first bad edge. A bad capture path gives a wrong rxData or rxCmd as soon as rxValid rises. A sweep of all 256 byte values with both auto-feed settings would expose it. A stale overrun flag or held byte left after initialise is seen a few clocks after the host releases the initialise line.

// File: rtl/parport_pkg.sv
package parport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_HOLD = 2'd2,
    ST_ACK  = 2'd3
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic strbFall;
    logic strbRise;
    logic initAct;
  } dpEvt_t;

endpackage

// File: rtl/parport_sync.sv
module parport_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= RESET_VAL;
        else       stg[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stg <= {STAGES{RESET_VAL}};
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/parport_datapath.sv
module parport_datapath
  import parport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobeN,
  input  logic              hostAutoFeedN,
  input  logic              hostInitN,
  input  logic              hostSelectInN,
  input  logic              localOnline,
  input  logic              localPaperOut,
  input  logic              localFault,
  input  dpCmd_t            cmd,
  output dpEvt_t            evt,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmd,
  output logic              selectOut,
  output logic              paperErr,
  output logic              faultN
);

  localparam int CTL_W = 3;

  logic [CTL_W-1:0] ctlRaw;
  logic [CTL_W-1:0] ctlSync;
  logic             strbS;
  logic             initS;
  logic             selInS;
  logic             strbPrev;

  assign ctlRaw = {hostStrobeN, hostInitN, hostSelectInN};

  parport_sync #(
    .WIDTH    (CTL_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({CTL_W{1'b1}})
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (ctlRaw),
    .q   (ctlSync)
  );

  assign strbS  = ctlSync[2];
  assign initS  = ctlSync[1];
  assign selInS = ctlSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbPrev <= 1'b1;
    else       strbPrev <= strbS;
  end

  assign evt.strbFall = strbPrev & ~strbS;
  assign evt.strbRise = ~strbPrev & strbS;
  assign evt.initAct  = ~initS;

  // host holds data and auto-feed across the trailing strobe edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxCmd  <= 1'b0;
    end else if (cmd.clear) begin
      rxData <= '0;
      rxCmd  <= 1'b0;
    end else if (cmd.capture) begin
      rxData <= hostData;
      rxCmd  <= ~hostAutoFeedN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selectOut <= 1'b0;
      paperErr  <= 1'b0;
      faultN    <= 1'b1;
    end else begin
      selectOut <= localOnline & ~selInS;
      paperErr  <= localPaperOut;
      faultN    <= ~localFault;
    end
  end

endmodule

// File: rtl/parport_ctrl.sv
module parport_ctrl
  import parport_pkg::*;
#(
  parameter int ACK_CYCLES = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpEvt_t evt,
  input  logic   rxReady,
  output dpCmd_t cmd,
  output logic   rxValid,
  output logic   busy,
  output logic   ackN,
  output logic   overrun
);

  localparam int              CNT_W    = $clog2(ACK_CYCLES + 1);
  localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(ACK_CYCLES - 1);

  rxState_e         state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             ovrNxt;

  always_comb begin
    stateNxt    = state;
    cntNxt      = cnt;
    ovrNxt      = overrun;
    cmd.capture = 1'b0;
    cmd.clear   = 1'b0;
    if (evt.initAct) begin
      stateNxt  = ST_IDLE;
      cntNxt    = '0;
      ovrNxt    = 1'b0;
      cmd.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (evt.strbRise) begin
            cmd.capture = 1'b1;
            stateNxt    = ST_HOLD;
          end else if (evt.strbFall) begin
            stateNxt = ST_STRB;
          end
        end
        ST_STRB: begin
          if (evt.strbRise) begin
            cmd.capture = 1'b1;
            stateNxt    = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (evt.strbRise) ovrNxt = 1'b1;
          if (rxReady) begin
            stateNxt = ST_ACK;
            cntNxt   = ACK_LOAD;
          end
        end
        ST_ACK: begin
          if (evt.strbRise) ovrNxt = 1'b1;
          if (cnt == '0) stateNxt = ST_IDLE;
          else           cntNxt   = cnt - 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      overrun <= ovrNxt;
    end
  end

  assign rxValid = (state == ST_HOLD);
  assign busy    = (state != ST_IDLE);
  assign ackN    = (state != ST_ACK);

endmodule

// File: rtl/parport_rx.sv
module parport_rx
  import parport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ACK_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobeN,
  input  logic              hostAutoFeedN,
  input  logic              hostInitN,
  input  logic              hostSelectInN,
  input  logic              localOnline,
  input  logic              localPaperOut,
  input  logic              localFault,
  input  logic              rxReady,
  output logic              ackN,
  output logic              busy,
  output logic              selectOut,
  output logic              paperErr,
  output logic              faultN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmd,
  output logic              rxValid,
  output logic              overrun
);

  dpCmd_t dpCmd;
  dpEvt_t dpEvt;

  parport_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .hostData     (hostData),
    .hostStrobeN  (hostStrobeN),
    .hostAutoFeedN(hostAutoFeedN),
    .hostInitN    (hostInitN),
    .hostSelectInN(hostSelectInN),
    .localOnline  (localOnline),
    .localPaperOut(localPaperOut),
    .localFault   (localFault),
    .cmd          (dpCmd),
    .evt          (dpEvt),
    .rxData       (rxData),
    .rxCmd        (rxCmd),
    .selectOut    (selectOut),
    .paperErr     (paperErr),
    .faultN       (faultN)
  );

  parport_ctrl #(
    .ACK_CYCLES(ACK_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (dpEvt),
    .rxReady(rxReady),
    .cmd    (dpCmd),
    .rxValid(rxValid),
    .busy   (busy),
    .ackN   (ackN),
    .overrun(overrun)
  );

endmodule

// File: rtl/parport_rx_chk.sv
module parport_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxReady,
  input logic              ackN,
  input logic              busy,
  input logic [DATA_W-1:0] rxData,
  input logic              rxCmd,
  input logic              rxValid,
  input logic              overrun
);

  AST_ACK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> busy); // R6

  AST_BUSY_DROPS_AT_ACK_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackN) |-> !busy); // R6

  AST_ACK_ONLY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(rxValid && rxReady)); // R7

  AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> busy); // R4

  AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && $past(rxValid) |-> $stable(rxData) && $stable(rxCmd)); // R5

  AST_OVERRUN_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> !rxValid && !busy); // R9

  AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ackN); // R11

endmodule

bind parport_rx parport_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rxReady(rxReady),
  .ackN   (ackN),
  .busy   (busy),
  .rxData (rxData),
  .rxCmd  (rxCmd),
  .rxValid(rxValid),
  .overrun(overrun)
);

// File: tb/parport_rx_tb.sv
module parport_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int ACK_CYCLES = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] hostData = '0;
  logic              hostStrobeN = 1'b1;
  logic              hostAutoFeedN = 1'b1;
  logic              hostInitN = 1'b1;
  logic              hostSelectInN = 1'b1;
  logic              localOnline = 1'b0;
  logic              localPaperOut = 1'b0;
  logic              localFault = 1'b0;
  logic              rxReady = 1'b0;
  logic              ackN, busy, selectOut, paperErr, faultN, rxCmd, rxValid, overrun;
  logic [DATA_W-1:0] rxData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parport_rx #(.DATA_W(DATA_W), .ACK_CYCLES(ACK_CYCLES), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostStrobeN(hostStrobeN),
    .hostAutoFeedN(hostAutoFeedN), .hostInitN(hostInitN), .hostSelectInN(hostSelectInN),
    .localOnline(localOnline), .localPaperOut(localPaperOut), .localFault(localFault),
    .rxReady(rxReady), .ackN(ackN), .busy(busy), .selectOut(selectOut),
    .paperErr(paperErr), .faultN(faultN), .rxData(rxData), .rxCmd(rxCmd),
    .rxValid(rxValid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] d, input bit af);
    @(negedge clk);
    hostData      = d;
    hostAutoFeedN = ~af;
    hostStrobeN   = 1'b0;
    repeat (3) @(negedge clk);
    hostStrobeN = 1'b1;
    repeat (5) @(negedge clk);
    hostAutoFeedN = 1'b1;
  endtask

  task automatic waitValid(input string req);
    int n = 0;
    while (!rxValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(rxValid == 1'b1, req, rxValid, 1);
  endtask

  // take the byte and measure the acknowledge pulse
  task automatic takeByte();
    int w = 0;
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    while (!ackN && w < 100) begin
      check(busy == 1'b1, "R6 busy during ack", busy, 1);
      @(negedge clk);
      w++;
    end
    check(w == ACK_CYCLES, "R6 ack width", w, ACK_CYCLES);
    check(busy == 1'b0, "R6 busy released with ack", busy, 0);
  endtask

  task automatic initPulse();
    @(negedge clk);
    hostInitN = 1'b0;
    repeat (4) @(negedge clk);
    hostInitN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ackN == 1'b1, "R1 ackN", ackN, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(rxData == '0, "R1 rxData", rxData, 0);

    // R4 busy on leading strobe edge, nothing presented yet
    @(negedge clk);
    hostData = 8'h5A;
    hostStrobeN = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R4 busy on strobe", busy, 1);
    check(rxValid == 1'b0, "R4 no byte before trailing edge", rxValid, 0);
    check(ackN == 1'b1, "R7 no ack before take", ackN, 1);
    hostStrobeN = 1'b1;
    repeat (5) @(negedge clk);
    waitValid("R2 valid after trailing edge");
    check(rxData == 8'h5A, "R2 data", rxData, 8'h5A);
    takeByte();

    // R2 R3 R5 R11 sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      logic [DATA_W-1:0] d = DATA_W'(v);
      bit af = d[0] ^ d[7];
      int hold = v % 5;
      sendByte(d, af);
      waitValid("R2 valid");
      check(rxData == d, "R2 data", rxData, d);
      check(rxCmd == af, "R3 command tag", rxCmd, af);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(rxValid && busy && ackN && rxData == d, "R11 back-pressure hold",
              {rxValid, busy, ackN}, 3'b111);
        check(rxData == d, "R5 held data stable", rxData, d);
      end
      takeByte();
    end

    // R8 overrun: second byte while first is held
    sendByte(8'hA5, 1'b0);
    waitValid("R8 first byte valid");
    sendByte(8'h3C, 1'b1);
    repeat (3) @(negedge clk);
    check(overrun == 1'b1, "R8 overrun set", overrun, 1);
    check(rxData == 8'hA5, "R8 held byte kept", rxData, 8'hA5);
    check(rxCmd == 1'b0, "R8 held tag kept", rxCmd, 0);
    takeByte();
    repeat (4) @(negedge clk);
    check(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
    // a normal byte afterwards leaves overrun set
    sendByte(8'h11, 1'b0);
    waitValid("R8 next byte valid");
    takeByte();
    check(overrun == 1'b1, "R8 overrun still set", overrun, 1);

    // R9 initialise clears overrun
    initPulse();
    check(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
    check(busy == 1'b0, "R9 busy cleared", busy, 0);

    // R9 initialise with a held byte: no acknowledge
    sendByte(8'hC3, 1'b1);
    waitValid("R9 byte valid before init");
    @(negedge clk);
    hostInitN = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 4) hostInitN = 1'b1;
      check(ackN == 1'b1, "R9 no ack around init", ackN, 1);
    end
    check(rxValid == 1'b0, "R9 rxValid cleared", rxValid, 0);
    check(busy == 1'b0, "R9 busy cleared", busy, 0);
    check(rxData == '0, "R9 rxData cleared", rxData, 0);
    check(rxCmd == 1'b0, "R9 rxCmd cleared", rxCmd, 0);
    sendByte(8'h77, 1'b1);
    waitValid("R9 transfer after init");
    check(rxData == 8'h77 && rxCmd, "R9 transfer after init data", rxData, 8'h77);
    takeByte();

    // R10 status outputs over all input combinations
    for (int s = 0; s < 16; s++) begin
      bit on = s[0];
      bit selN = s[1];
      bit po = s[2];
      bit fl = s[3];
      @(negedge clk);
      localOnline = on;
      hostSelectInN = selN;
      localPaperOut = po;
      localFault = fl;
      repeat (5) @(negedge clk);
      check(selectOut == (on & ~selN), "R10 select", selectOut, on & ~selN);
      check(paperErr == po, "R10 paper error", paperErr, po);
      check(faultN == ~fl, "R10 fault", faultN, ~fl);
    end

    finishRun();
  end

endmodule